// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block sorts the fields of an interlaced video input into odd and even. It counts clocks from the rising edge of each horizontal sync pulse. When a vertical sync pulse begins, it looks at where that moment falls within the current line. If the edge lands inside a window, the new field is odd. If it lands anywhere else, the field is even. Two 3-bit selects set the window edges, and each select picks one offset from a fixed set of values.

An invert control swaps the meaning of the result. This suits sources whose sync timing places the even field inside the window. Downstream logic reads a registered parity flag. It also receives a one-cycle strobe that marks the start of each new field.

Top module: `fieldParityDetector`

## Requirements
- R1: During and right after reset, `fieldOdd` and `fieldStart` are both 0.
- R2: `fieldStart` is high for exactly one cycle. That cycle directly follows the first clock edge at which `vsyncIn` is sampled high after being sampled low. At no other time is `fieldStart` high.
- R3: The line offset of a clock edge counts the edges since the latest edge at which `hsyncIn` was sampled rising. The rising-edge sample itself has offset 0. The offset stops at 2047. Before the first HSYNC rise after reset, the offset is 2047.
- R4: A select value of 0 means offset 0. A select value n from 1 to 7 means offset 2^(n+3), so the set is 16, 32, 64, 128, 256, 512 and 1024. `winStartSel` picks the first offset inside the window, and `winEndSel` picks the first offset past it.
- R5: With `invertParity`=0, a VSYNC rise whose offset meets start <= offset < end sets `fieldOdd` to 1 on the next cycle.
- R6: With `invertParity`=0, a VSYNC rise whose offset lies outside the window sets `fieldOdd` to 0 on the next cycle.
- R7: When start >= end, the window is empty and every field is even, before any inversion.
- R8: With `invertParity`=1, the parity stored at a VSYNC rise is the complement of the R5/R6/R7 result.
- R9: `fieldOdd` changes only in the cycle in which `fieldStart` is high. Changing the selects or `invertParity` between VSYNC rises has no effect on it.
- R10: If `hsyncIn` and `vsyncIn` rise at the same sampled edge, the VSYNC rise has offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| hsyncIn | input | 1 | Horizontal sync, active high, already synchronous to clk |
| vsyncIn | input | 1 | Vertical sync, active high, already synchronous to clk |
| winStartSel | input | 3 | Window start offset select |
| winEndSel | input | 3 | Window end offset select |
| invertParity | input | 1 | Swaps the odd and even results |
| fieldOdd | output | 1 | Parity of the current field, 1 = odd |
| fieldStart | output | 1 | One-cycle strobe marking a new field |

## Verification
Two events can fall in the same cycle: the line counter restarting on an HSYNC rise, and the parity decision on a VSYNC rise. Every select pair is run with VSYNC placed at offset 0, which drives both syncs high on the same negative clock edge. The expected result treats that edge as offset 0, so start select 0 must give odd. The window boundaries start-1, start, end-1 and end are also probed for all 64 select pairs. Each expected parity is computed from the offset arithmetic.

// File: rtl/fieldParityPkg.sv
package fieldParityPkg;

  typedef struct packed {
    logic lineStart;  // HSYNC rising edge sampled this cycle
    logic fieldEdge;  // VSYNC rising edge sampled this cycle
  } ctrlStrobe_t;

  // Maps a select code to a clock offset from the HSYNC rising edge.
  function automatic int unsigned selOffset(input int unsigned sel, input int unsigned baseLog2);
    if (sel == 0) return 0;
    return 32'd1 << (sel + baseLog2);
  endfunction

endpackage

// File: rtl/syncEdgeCtrl.sv
module syncEdgeCtrl
  import fieldParityPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hsyncIn,
  input  logic        vsyncIn,
  output ctrlStrobe_t strobes
);

  logic hsPrev;
  logic vsPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev <= 1'b0;
      vsPrev <= 1'b0;
    end else begin
      hsPrev <= hsyncIn;
      vsPrev <= vsyncIn;
    end
  end

  always_comb begin
    strobes.lineStart = hsyncIn & ~hsPrev;
    strobes.fieldEdge = vsyncIn & ~vsPrev;
  end

endmodule

// File: rtl/winDatapath.sv
module winDatapath
  import fieldParityPkg::*;
#(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobes,
  input  logic [SEL_W-1:0] startSel,
  input  logic [SEL_W-1:0] endSel,
  input  logic             invertParity,
  output logic             fieldOdd,
  output logic             fieldStart
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] curPos;
  int unsigned      winLo;
  int unsigned      winHi;
  int unsigned      posExt;
  logic             inWin;

  // Offset of the current edge: 0 on the HSYNC rise itself.
  always_comb curPos = strobes.lineStart ? '0 : lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= CNT_MAX;
    end else if (strobes.lineStart) begin
      lineCnt <= CNT_W'(1);
    end else if (lineCnt != CNT_MAX) begin
      lineCnt <= lineCnt + CNT_W'(1);
    end
  end

  always_comb begin
    winLo  = selOffset(32'(startSel), BASE_LOG2);
    winHi  = selOffset(32'(endSel), BASE_LOG2);
    posExt = 32'(curPos);
    inWin  = (posExt >= winLo) && (posExt < winHi);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldOdd   <= 1'b0;
      fieldStart <= 1'b0;
    end else begin
      fieldStart <= strobes.fieldEdge;
      if (strobes.fieldEdge) fieldOdd <= inWin ^ invertParity;
    end
  end

endmodule

// File: rtl/fieldParityDetector.sv
module fieldParityDetector
  import fieldParityPkg::*;
#(
  parameter int unsigned CNT_W     = 11,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic [SEL_W-1:0] winStartSel,
  input  logic [SEL_W-1:0] winEndSel,
  input  logic             invertParity,
  output logic             fieldOdd,
  output logic             fieldStart
);

  ctrlStrobe_t strobes;

  syncEdgeCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .hsyncIn (hsyncIn),
    .vsyncIn (vsyncIn),
    .strobes (strobes)
  );

  winDatapath #(
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .startSel     (winStartSel),
    .endSel       (winEndSel),
    .invertParity (invertParity),
    .fieldOdd     (fieldOdd),
    .fieldStart   (fieldStart)
  );

endmodule

// File: rtl/fieldParityChk.sv
module fieldParityChk #(
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             hsyncIn,
  input logic             vsyncIn,
  input logic [SEL_W-1:0] winStartSel,
  input logic [SEL_W-1:0] winEndSel,
  input logic             invertParity,
  input logic             fieldOdd,
  input logic             fieldStart
);

  logic hsQ;
  logic vsQ;
  logic vsEdge;
  logic hsEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsQ <= 1'b0;
      vsQ <= 1'b0;
    end else begin
      hsQ <= hsyncIn;
      vsQ <= vsyncIn;
    end
  end

  always_comb begin
    vsEdge = vsyncIn && !vsQ;
    hsEdge = hsyncIn && !hsQ;
  end

  AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    vsEdge |=> fieldStart);  // R2
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !vsEdge |=> !fieldStart);  // R2
  AST_PARITY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !fieldStart |-> $stable(fieldOdd));  // R9
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (vsEdge && (winStartSel >= winEndSel)) |=> (fieldOdd == $past(invertParity)));  // R7
  AST_SAME_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (vsEdge && hsEdge && (winStartSel == '0) && (winEndSel != '0))
      |=> (fieldOdd == !$past(invertParity)));  // R10

endmodule

bind fieldParityDetector fieldParityChk #(.SEL_W(SEL_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .hsyncIn      (hsyncIn),
  .vsyncIn      (vsyncIn),
  .winStartSel  (winStartSel),
  .winEndSel    (winEndSel),
  .invertParity (invertParity),
  .fieldOdd     (fieldOdd),
  .fieldStart   (fieldStart)
);

// File: tb/fieldParityDetector_tb_top.sv
module fieldParityDetector_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncIn = 1'b0;
  logic       vsyncIn = 1'b0;
  logic [2:0] winStartSel = '0;
  logic [2:0] winEndSel = '0;
  logic       invertParity = 1'b0;
  logic       fieldOdd;
  logic       fieldStart;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit timedOut = 1'b0;

  always #10 clk = ~clk;

  fieldParityDetector dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .hsyncIn      (hsyncIn),
    .vsyncIn      (vsyncIn),
    .winStartSel  (winStartSel),
    .winEndSel    (winEndSel),
    .invertParity (invertParity),
    .fieldOdd     (fieldOdd),
    .fieldStart   (fieldStart)
  );

  function automatic int offOf(input int sel);
    return (sel == 0) ? 0 : (1 << (sel + 3));  // R4
  endfunction

  function automatic bit expParity(input int s, input int e, input bit inv, input int d);
    int off;
    off = (d > 2047) ? 2047 : d;  // R3
    return ((off >= offOf(s)) && (off < offOf(e))) ^ inv;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // HSYNC rise sampled at offset 0, VSYNC rise d edges later.
  task automatic trial(input int s, input int e, input bit inv, input int d);
    @(negedge clk);
    winStartSel  = 3'(s);
    winEndSel    = 3'(e);
    invertParity = inv;
    hsyncIn = 1'b1;
    if (d == 0) vsyncIn = 1'b1;
    for (int i = 1; i <= d; i++) begin
      @(negedge clk);
      if (i == 1) hsyncIn = 1'b0;
      if (i == d) vsyncIn = 1'b1;
    end
    @(negedge clk);
    check("R2 strobe", fieldStart, 1);
    if (d == 0)
      check("R10 same-edge parity", fieldOdd, expParity(s, e, inv, d));
    else if (s >= e)
      check("R7 empty window parity", fieldOdd, expParity(s, e, inv, d));
    else if (inv)
      check("R8 inverted parity", fieldOdd, expParity(s, e, inv, d));
    else
      check("R5/R6 window parity", fieldOdd, expParity(s, e, inv, d));
    vsyncIn = 1'b0;
    hsyncIn = 1'b0;
    @(negedge clk);
    check("R2 single pulse", fieldStart, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        timedOut = 1'b1;
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset fieldOdd", fieldOdd, 0);
    check("R1 reset fieldStart", fieldStart, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset fieldOdd", fieldOdd, 0);
    check("R1 after reset fieldStart", fieldStart, 0);

    // R3: no HSYNC yet, so the offset is saturated at 2047 (outside 0..1024).
    winStartSel = 3'd0; winEndSel = 3'd7; invertParity = 1'b1;
    vsyncIn = 1'b1;
    @(negedge clk);
    check("R3 saturated before first hsync", fieldOdd, 1);
    vsyncIn = 1'b0;
    @(negedge clk);

    // Sweep all select pairs at the window boundaries.
    for (int s = 0; s < 8; s++) begin
      for (int e = 0; e < 8; e++) begin
        bit inv;
        inv = bit'((s + e) & 1);
        trial(s, e, inv, 0);
        if (offOf(s) > 0) trial(s, e, inv, offOf(s) - 1);
        trial(s, e, inv, offOf(s));
        if (offOf(e) > 0) trial(s, e, inv, offOf(e) - 1);
        trial(s, e, inv, offOf(e));
      end
    end

    // R3: saturation within a line.
    trial(0, 7, 1'b0, 2100);
    trial(1, 2, 1'b1, 20);

    // R9: control changes between fields leave parity alone.
    trial(1, 3, 1'b0, 20);  // odd
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      winStartSel  = 3'(k);
      winEndSel    = 3'(7 - k);
      invertParity = ~invertParity;
      check("R9 parity held", fieldOdd, 1);
      check("R9 no strobe", fieldStart, 0);
    end

    if (!timedOut) begin
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule